// File: doc/BRIEF.md
# Self-Programmable Cellular Automaton Random Bit Source

This block is a one-dimensional ring or line of cells. Each cell holds two bits: a state bit and a meta-state bit. On every enabled clock, each cell picks one of two three-neighbour rules for its next state bit. Its own meta-state bit makes the choice. Each cell's next meta-state bit is the XOR of two other cells' state bits, taken at fixed signed offsets from the cell.

The block shows every state and meta-state bit on one wide output, so it yields twice as many random bits per cycle as it has cells. Software or a neighbouring block seeds it through a parallel load strobe. It can then let it run freely, or step it only when bits are consumed, by holding the enable input. Parameters set the cell count, the rule pair, the two meta-state offsets, and the edge treatment. The edge treatment is either constant zero or wrap-around.

A small control decoder turns reset, load and enable into one of four operations per cycle, with reset highest, then load. The operations are INIT, LOAD, STEP and HOLD. All four transitions follow from the inputs of the current cycle alone: rst gives INIT, load gives LOAD, en gives STEP, and otherwise HOLD.

Top module: `spca_rng`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the register bank is loaded with `INIT_SEED`. The default `INIT_SEED` is the pattern with every odd bit set, which is 32'hAAAAAAAA for 16 cells.
- R2: When `load` is high and `rst` is low, the bank takes `seed` on the next edge, whatever `en` is. Bits [CELLS-1:0] of `seed` and of `rnd_out` are the state bits of cells 0..CELLS-1. Bits [2*CELLS-1:CELLS] are the meta-state bits of the same cells.
- R3: When `rst`, `load` and `en` are all low, `rnd_out` keeps its value across the edge.
- R4: On a step, the next state bit of cell i is bit {S[i+1], S[i], S[i-1]} of `RULE_A` when its meta-state bit is 0, and of `RULE_B` when it is 1. In that index, S[i+1] is the most significant bit.
- R5: On a step, the next meta-state bit of cell i is S[i+OFS_M] XOR S[i+OFS_N], using the current state bits.
- R6: With `WRAP`=1, any neighbour index outside 0..CELLS-1 wraps modulo CELLS. Cell 0 then sees cell CELLS-1 as its lower neighbour, and cell CELLS-1 sees cell 0 as its upper neighbour.
- R7: With `WRAP`=0, any neighbour index outside 0..CELLS-1 reads as 0.
- R8: Both complementary linear rule pairs work as parameter values: 150 with 105, and 90 with 165.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads INIT_SEED |
| en | input | 1 | Advance the automaton by one generation |
| load | input | 1 | Load `seed` into the bank (takes priority over `en`) |
| seed | input | 2*CELLS | Seed value: meta bits in the upper half, state bits in the lower half |
| rnd_out | output | 2*CELLS | All meta-state (upper half) and state (lower half) bits |

## Verification
The assertions assume that `load`, `en` and `seed` are stable around the rising edge. They also assume that a reset lasts at least one edge before their checks start. The bench meets both by changing inputs only on falling edges and by releasing reset only after two edges. The offset checks assume |OFS_M| and |OFS_N| are below CELLS, so the wrapped index is well defined. Both bench instances use offsets of magnitude 3 or less with 16 cells. The stimulus includes a single-bit seed at each end of the line, so that the edge treatment is exercised.

// File: rtl/spca_pkg.sv
package spca_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2,
        OP_INIT = 2'd3
    } spca_op_e;

    // Resolve a raw neighbour index into 0..k-1 by modulo wrap.
    function automatic int wrap_idx(input int raw, input int k);
        return ((raw % k) + k) % k;
    endfunction

    function automatic bit in_range(input int raw, input int k);
        return (raw >= 0) && (raw < k);
    endfunction

endpackage

// File: rtl/spca_tap.sv
module spca_tap #(
    parameter int CELLS = 16,
    parameter int RAW   = 0,
    parameter bit WRAP  = 1'b1
) (
    input  logic [CELLS-1:0] states,
    output logic             tap_o
);
    import spca_pkg::*;

    localparam int  POS  = wrap_idx(RAW, CELLS);
    localparam bit  LIVE = WRAP || in_range(RAW, CELLS);

    generate
        if (LIVE) begin : g_live
            assign tap_o = states[POS];
        end else begin : g_null
            assign tap_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/spca_cell.sv
module spca_cell #(
    parameter int         CELLS  = 16,
    parameter int         IDX    = 0,
    parameter logic [7:0] RULE_A = 8'd150,
    parameter logic [7:0] RULE_B = 8'd105,
    parameter int         OFS_M  = -3,
    parameter int         OFS_N  = 1,
    parameter bit         WRAP   = 1'b1
) (
    input  logic [CELLS-1:0] states,
    input  logic             meta_i,
    output logic             nxt_state,
    output logic             nxt_meta
);
    logic up_nb, lo_nb, tap_m, tap_n;
    logic [2:0] hood;
    logic [7:0] rule_sel;

    spca_tap #(.CELLS(CELLS), .RAW(IDX + 1), .WRAP(WRAP)) u_up (
        .states(states), .tap_o(up_nb));
    spca_tap #(.CELLS(CELLS), .RAW(IDX - 1), .WRAP(WRAP)) u_lo (
        .states(states), .tap_o(lo_nb));
    spca_tap #(.CELLS(CELLS), .RAW(IDX + OFS_M), .WRAP(WRAP)) u_tm (
        .states(states), .tap_o(tap_m));
    spca_tap #(.CELLS(CELLS), .RAW(IDX + OFS_N), .WRAP(WRAP)) u_tn (
        .states(states), .tap_o(tap_n));

    always_comb begin
        hood      = {up_nb, states[IDX], lo_nb};
        rule_sel  = meta_i ? RULE_B : RULE_A;
        nxt_state = rule_sel[hood];
        nxt_meta  = tap_m ^ tap_n;
    end

endmodule

// File: rtl/spca_ctrl.sv
module spca_ctrl (
    input  logic              rst,
    input  logic              load,
    input  logic              en,
    output spca_pkg::spca_op_e op
);
    import spca_pkg::*;

    always_comb begin
        if (rst)       op = OP_INIT;
        else if (load) op = OP_LOAD;
        else if (en)   op = OP_STEP;
        else           op = OP_HOLD;
    end

endmodule

// File: rtl/spca_rng.sv
module spca_rng #(
    parameter int                   CELLS     = 16,
    parameter logic [7:0]           RULE_A    = 8'd150,
    parameter logic [7:0]           RULE_B    = 8'd105,
    parameter int                   OFS_M     = -3,
    parameter int                   OFS_N     = 1,
    parameter bit                   WRAP      = 1'b1,
    parameter logic [2*CELLS-1:0]   INIT_SEED = {CELLS{2'b10}}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 load,
    input  logic [2*CELLS-1:0]   seed,
    output logic [2*CELLS-1:0]   rnd_out
);
    import spca_pkg::*;

    localparam int W = 2 * CELLS;

    spca_op_e         op;
    logic [W-1:0]     bank;
    logic [CELLS-1:0] st_q, mt_q, st_d, mt_d;

    assign st_q = bank[CELLS-1:0];
    assign mt_q = bank[W-1:CELLS];

    spca_ctrl u_ctrl (.rst(rst), .load(load), .en(en), .op(op));

    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_cell
            spca_cell #(
                .CELLS(CELLS), .IDX(i), .RULE_A(RULE_A), .RULE_B(RULE_B),
                .OFS_M(OFS_M), .OFS_N(OFS_N), .WRAP(WRAP)
            ) u_cell (
                .states(st_q), .meta_i(mt_q[i]),
                .nxt_state(st_d[i]), .nxt_meta(mt_d[i])
            );
        end
    endgenerate

    // Register process
    always_ff @(posedge clk) begin
        unique case (op)
            OP_INIT: bank <= INIT_SEED;
            OP_LOAD: bank <= seed;
            OP_STEP: bank <= {mt_d, st_d};
            OP_HOLD: bank <= bank;
            default: bank <= bank;
        endcase
    end

    // Output process
    always_comb rnd_out = bank;

endmodule

// File: rtl/spca_rng_chk.sv
module spca_rng_chk #(
    parameter int                   CELLS     = 16,
    parameter logic [7:0]           RULE_A    = 8'd150,
    parameter logic [7:0]           RULE_B    = 8'd105,
    parameter int                   OFS_M     = -3,
    parameter int                   OFS_N     = 1,
    parameter bit                   WRAP      = 1'b1,
    parameter logic [2*CELLS-1:0]   INIT_SEED = {CELLS{2'b10}}
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 load,
    input logic [2*CELLS-1:0]   seed,
    input logic [2*CELLS-1:0]   rnd_out
);
    localparam int LW = (CELLS > 1) ? $clog2(CELLS) : 1;

    function automatic logic pick(input logic [CELLS-1:0] v, input int raw);
        int w;
        w = ((raw % CELLS) + CELLS) % CELLS;
        if (!WRAP && (raw < 0 || raw >= CELLS)) return 1'b0;
        return v[w[LW-1:0]];
    endfunction

    function automatic logic apply(input logic m, input logic l,
                                   input logic c, input logic r);
        logic [7:0] rr;
        rr = m ? RULE_B : RULE_A;
        return rr[{l, c, r}];
    endfunction

    // R1
    init_seed_chk: assert property (@(posedge clk) rst |=> rnd_out == INIT_SEED);

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> rnd_out == $past(seed));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(rnd_out));

    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_c
            // R4
            state_rule_chk: assert property (@(posedge clk) disable iff (rst)
                (!load && en) |=> rnd_out[i] == apply($past(rnd_out[CELLS+i]),
                    pick($past(rnd_out[CELLS-1:0]), i + 1),
                    $past(rnd_out[i]),
                    pick($past(rnd_out[CELLS-1:0]), i - 1)));
            // R5
            meta_xor_chk: assert property (@(posedge clk) disable iff (rst)
                (!load && en) |=> rnd_out[CELLS+i] ==
                    (pick($past(rnd_out[CELLS-1:0]), i + OFS_M) ^
                     pick($past(rnd_out[CELLS-1:0]), i + OFS_N)));
        end
    endgenerate

endmodule

bind spca_rng spca_rng_chk #(
    .CELLS(CELLS), .RULE_A(RULE_A), .RULE_B(RULE_B), .OFS_M(OFS_M),
    .OFS_N(OFS_N), .WRAP(WRAP), .INIT_SEED(INIT_SEED)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .rnd_out(rnd_out)
);

// File: tb/sim_spca_rng.sv
module sim_spca_rng;
    localparam int K      = 16;
    localparam int PERIOD = 10;

    typedef struct {
        logic [2*K-1:0] e0;
        logic [2*K-1:0] e1;
        string          tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1, en = 1'b0, load = 1'b0;
    logic [2*K-1:0] seed = '0;
    logic [2*K-1:0] out0, out1;

    int checks = 0, failures = 0;
    bit done = 0;
    exp_t sb[$];
    logic [2*K-1:0] mdl0, mdl1;

    always #(PERIOD/2) clk = ~clk;

    // u0: periodic, rules 150/105, offsets -3 / +1 (R6)
    spca_rng #(.CELLS(K), .RULE_A(8'd150), .RULE_B(8'd105),
               .OFS_M(-3), .OFS_N(1), .WRAP(1'b1)) u0 (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .rnd_out(out0));

    // u1: null boundary, rules 90/165, offsets +2 / -1 (R7, R8)
    spca_rng #(.CELLS(K), .RULE_A(8'd90), .RULE_B(8'd165),
               .OFS_M(2), .OFS_N(-1), .WRAP(1'b0)) u1 (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .rnd_out(out1));

    function automatic logic nb(input logic [K-1:0] s, input int raw, input bit wrap);
        if (raw >= 0 && raw < K) return s[raw];
        if (!wrap) return 1'b0;
        return s[((raw % K) + K) % K];
    endfunction

    function automatic logic [2*K-1:0] gen(input logic [2*K-1:0] v,
            input logic [7:0] ra, input logic [7:0] rb,
            input int m, input int n, input bit wrap);
        logic [K-1:0] s, mt, ns, nm;
        s  = v[K-1:0];
        mt = v[2*K-1:K];
        for (int i = 0; i < K; i++) begin
            int idx;
            idx = 4 * int'(nb(s, i + 1, wrap)) + 2 * int'(s[i]) + int'(nb(s, i - 1, wrap));
            ns[i] = mt[i] ? rb[idx] : ra[idx];
            nm[i] = nb(s, i + m, wrap) ^ nb(s, i + n, wrap);
        end
        return {nm, ns};
    endfunction

    task automatic drive(input logic r, input logic ld, input logic e,
                         input logic [2*K-1:0] sd, input string tag);
        exp_t x;
        @(negedge clk);
        rst = r; load = ld; en = e; seed = sd;
        if (r) begin
            mdl0 = {K{2'b10}};
            mdl1 = {K{2'b10}};
        end else if (ld) begin
            mdl0 = sd;
            mdl1 = sd;
        end else if (e) begin
            mdl0 = gen(mdl0, 8'd150, 8'd105, -3, 1, 1'b1);
            mdl1 = gen(mdl1, 8'd90, 8'd165, 2, -1, 1'b0);
        end
        x.e0 = mdl0; x.e1 = mdl1; x.tag = tag;
        sb.push_back(x);
    endtask

    // Monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                checks += 2;
                if (out0 !== x.e0) begin
                    failures++;
                    $display("FAIL %s u0 actual=%h expected=%h", x.tag, out0, x.e0);
                end
                if (out1 !== x.e1) begin
                    failures++;
                    $display("FAIL %s u1 actual=%h expected=%h", x.tag, out1, x.e1);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        drive(1, 0, 0, '0, "R1 reset seed");
        drive(1, 0, 0, '0, "R1 reset seed");
        for (int i = 0; i < 12; i++) drive(0, 0, 1, '0, "R4 R5 step from default");
        drive(0, 0, 0, '0, "R3 hold");
        drive(0, 0, 0, 32'h1234_5678, "R3 hold ignores seed");
        drive(0, 1, 1, 32'h0000_0001, "R2 load beats enable");
        for (int i = 0; i < 4; i++) drive(0, 0, 1, '0, "R6 R7 low-edge propagation");
        drive(0, 1, 0, 32'h0000_8000, "R2 load top cell");
        for (int i = 0; i < 4; i++) drive(0, 0, 1, '0, "R6 R7 high-edge propagation");
        drive(0, 1, 0, 32'hFFFF_0000, "R2 load all-meta");
        for (int i = 0; i < 3; i++) drive(0, 0, 1, '0, "R4 R8 second rule selected");
        drive(0, 1, 0, 32'h0000_0000, "R2 load zero");
        drive(0, 0, 1, '0, "R4 zero neighbourhood");
        drive(0, 1, 0, 32'h9E37_79B9, "R2 load mixed");
        for (int i = 0; i < 40; i++) drive(0, 0, (i % 3) != 0, '0, "R3 R5 R8 gated run");
        drive(1, 0, 1, '0, "R1 reset mid-run");
        @(negedge clk);
        rst = 0; en = 0; load = 0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule